// File: doc/BRIEF.md
# Calendar Real-Time Counter with Field-Masked Alarm

This block keeps wall-clock time and a calendar: second, minute, hour, day of week, day of month, month and a two-digit year. It advances once for each pulse on a one-second enable input. The one-second pulse comes from a prescaler elsewhere on the chip. Month lengths are applied on their own, and so is the February length in leap years. The whole calendar wraps from the last second of year 99 back to the first second of year 00.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read port. A write to a time field is staged and applied on the next one-second pulse in place of that pulse's increment, so the count never pauses. An alarm compares the calendar against stored minute, hour, day, month and year values. Each of these fields has its own enable bit, so any subset can be matched. An interval timer counts seconds and raises an interrupt either once or at every interval.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads second 0, minute 0, hour 0, day of week 0, day 1, month 1, year 0; the alarm and timer interrupt outputs are low and status reads 0.
- R2: Each secTick pulse advances the second. 59 wraps to 0 and carries into the minute, minute 59 wraps to 0 and carries into the hour, and hour 23 wraps to 0. Without secTick the time fields do not change.
- R3: At midnight the day of week steps 0..6 and wraps to 0. The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R4: February has 29 days when year[1:0] is 0 (year 00 included) and 28 days otherwise.
- R5: A write to a time address (0 second, 1 minute, 2 hour, 3 day of week, 4 day, 5 month, 6 year) is not visible until the next secTick. On that tick all staged fields load and no field increments. A write in the same cycle as secTick loads at once, and that tick's increment is dropped.
- R6: The alarm is checked only when the second rolls from 59 to 0 through an increment. Mask register (address 12) bits select fields: bit0 minute (addr 7), bit1 hour (8), bit2 day (9), bit3 month (10), bit4 year (11). If the mask is non-zero and every enabled field equals the calendar, status bit0 is set one clock after the rollover edge. A zero mask never fires.
- R7: The alarm flag stays set until software writes 1 to status bit0 (address 15). alarmIrq mirrors status bit0. If a new match and the clear fall in the same cycle, the match wins.
- R8: The timer interval is set at address 13 (0 disables the timer). Control register 14 has bit0 run and bit1 repeat, and a write to it restarts the count. With run and repeat both set, status bit1 and timerIrq are set on every Nth secTick edge. Writing 1 to status bit1 clears the flag.
- R9: With run set and repeat clear, the timer fires once after N ticks and then clears its run bit, which reads back as 0.
- R10: Alarm value, mask, interval and control registers read back the value written, on rdData at rdAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-second enable, one clock wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| alarmIrq | output | 1 | Alarm interrupt, sticky |
| timerIrq | output | 1 | Interval timer interrupt, sticky |

## Verification
Time fields and the timer flag change at the same edge that samples secTick. The bench raises secTick for one cycle on a falling edge and reads the result at the following falling edge. The alarm flag is one register later than the rollover, so the bench checks it low at the first falling edge after the rollover tick and high one cycle later. Staged writes need two ticks before a value can be seen to increment: the first loads it and the second counts. The vector loop follows that pattern, and the reads go through the combinational read port half a cycle after each edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_TIME = 7;
  localparam int NUM_ALARM = 5;
  // time field addresses
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DAY  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  // other register addresses
  localparam int A_ALARM0 = 7;   // minute, hour, day, month, year at 7..11
  localparam int A_MASK   = 12;
  localparam int A_IVL    = 13;
  localparam int A_TCTL   = 14;
  localparam int A_STAT   = 15;

  typedef struct packed {
    logic inc;   // normal one-second advance
    logic load;  // apply staged and current writes instead of advancing
  } rtcStrobe_t;

  function automatic logic [7:0] resetValue(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'd1 : 8'd0;
  endfunction

  // calendar field compared by alarm slot j
  function automatic int alarmField(input int j);
    case (j)
      0: return F_MIN;
      1: return F_HOUR;
      2: return F_DAY;
      3: return F_MON;
      default: return F_YEAR;
    endcase
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'd2: return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default: return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rtcStrobe_t                        strobe,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [NUM_TIME-1:0][DATA_W-1:0]   timeVec,
  output logic [NUM_ALARM-1:0][DATA_W-1:0]  alarmVec,
  output logic [NUM_ALARM-1:0]              alarmMask,
  output logic                              stageAny,
  output logic                              secAtMax,
  output logic                              alarmMatch
);
  logic [NUM_TIME-1:0][DATA_W-1:0] timeQ, nextTime, stageQ;
  logic [NUM_TIME-1:0]             stageV, wrNow;
  logic [NUM_ALARM-1:0]            fieldOk;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, dayCarry;
  logic [DATA_W-1:0] monthLen;

  assign timeVec  = timeQ;
  assign stageAny = |stageV;
  assign secAtMax = secWrap;

  // calendar increment
  always_comb begin
    nextTime = timeQ;
    monthLen = DATA_W'(daysInMonth(8'(timeQ[F_MON]), 8'(timeQ[F_YEAR])));
    secWrap  = timeQ[F_SEC]  >= DATA_W'(59);
    minWrap  = timeQ[F_MIN]  >= DATA_W'(59);
    hourWrap = timeQ[F_HOUR] >= DATA_W'(23);
    dayWrap  = timeQ[F_DAY]  >= monthLen;
    monWrap  = timeQ[F_MON]  >= DATA_W'(12);
    dayCarry = secWrap && minWrap && hourWrap;
    nextTime[F_SEC] = secWrap ? '0 : timeQ[F_SEC] + 1'b1;
    if (secWrap)
      nextTime[F_MIN] = minWrap ? '0 : timeQ[F_MIN] + 1'b1;
    if (secWrap && minWrap)
      nextTime[F_HOUR] = hourWrap ? '0 : timeQ[F_HOUR] + 1'b1;
    if (dayCarry) begin
      nextTime[F_DOW] = (timeQ[F_DOW] >= DATA_W'(6)) ? '0 : timeQ[F_DOW] + 1'b1;
      nextTime[F_DAY] = dayWrap ? DATA_W'(1) : timeQ[F_DAY] + 1'b1;
    end
    if (dayCarry && dayWrap)
      nextTime[F_MON] = monWrap ? DATA_W'(1) : timeQ[F_MON] + 1'b1;
    if (dayCarry && dayWrap && monWrap)
      nextTime[F_YEAR] = (timeQ[F_YEAR] >= DATA_W'(99)) ? '0 : timeQ[F_YEAR] + 1'b1;
  end

  // per-field time register with staging
  for (genvar i = 0; i < NUM_TIME; i++) begin : g_time
    assign wrNow[i] = wrEn && (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        timeQ[i]  <= DATA_W'(resetValue(i));
        stageQ[i] <= '0;
        stageV[i] <= 1'b0;
      end else begin
        if (strobe.load) begin
          if (wrNow[i])       timeQ[i] <= wrData;
          else if (stageV[i]) timeQ[i] <= stageQ[i];
          stageV[i] <= 1'b0;
        end else begin
          if (strobe.inc) timeQ[i] <= nextTime[i];
          if (wrNow[i]) begin
            stageQ[i] <= wrData;
            stageV[i] <= 1'b1;
          end
        end
      end
    end
  end

  // alarm value registers and per-field comparison
  for (genvar j = 0; j < NUM_ALARM; j++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rstN)
        alarmVec[j] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(A_ALARM0 + j))
        alarmVec[j] <= wrData;
    end
    assign fieldOk[j] = !alarmMask[j] || (timeQ[alarmField(j)] == alarmVec[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      alarmMask <= '0;
    else if (wrEn && wrAddr == ADDR_W'(A_MASK))
      alarmMask <= wrData[NUM_ALARM-1:0];
  end

  assign alarmMatch = (|alarmMask) && (&fieldOk);
endmodule

// File: rtl/rtc_control.sv
module rtc_control
  import rtc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               secTick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               stageAny,
  input  logic               secAtMax,
  input  logic               alarmMatch,
  output rtcStrobe_t         strobe,
  output logic               alarmFlag,
  output logic               timerFlag,
  output logic [TIMER_W-1:0] tmrIvl,
  output logic               tmrRun,
  output logic               tmrRep
);
  logic timeWrNow, evalPend, alarmHit, tmrFire;
  logic statWr, ctlWr;
  logic [TIMER_W-1:0] tmrCnt;
  logic [TIMER_W:0]   cntNext;

  assign timeWrNow   = wrEn && (wrAddr < ADDR_W'(NUM_TIME));
  assign strobe.load = secTick && (stageAny || timeWrNow);
  assign strobe.inc  = secTick && !(stageAny || timeWrNow);

  assign statWr = wrEn && (wrAddr == ADDR_W'(A_STAT));
  assign ctlWr  = wrEn && (wrAddr == ADDR_W'(A_TCTL));

  // alarm: evaluated on the cycle after the second rolls to zero
  always_ff @(posedge clk) begin
    if (!rstN) evalPend <= 1'b0;
    else       evalPend <= strobe.inc && secAtMax;
  end
  assign alarmHit = evalPend && alarmMatch;

  always_ff @(posedge clk) begin
    if (!rstN)                      alarmFlag <= 1'b0;
    else if (alarmHit)              alarmFlag <= 1'b1;
    else if (statWr && wrData[0])   alarmFlag <= 1'b0;
  end

  // interval timer
  assign cntNext = {1'b0, tmrCnt} + 1'b1;
  assign tmrFire = secTick && tmrRun && (tmrIvl != '0) && !ctlWr &&
                   (cntNext >= {1'b0, tmrIvl});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrIvl <= '0;
      tmrRun <= 1'b0;
      tmrRep <= 1'b0;
      tmrCnt <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_W'(A_IVL))
        tmrIvl <= wrData[TIMER_W-1:0];
      if (ctlWr) begin
        tmrRun <= wrData[0];
        tmrRep <= wrData[1];
        tmrCnt <= '0;
      end else if (tmrFire) begin
        tmrCnt <= '0;
        if (!tmrRep) tmrRun <= 1'b0;
      end else if (secTick && tmrRun && tmrIvl != '0) begin
        tmrCnt <= cntNext[TIMER_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      timerFlag <= 1'b0;
    else if (tmrFire)               timerFlag <= 1'b1;
    else if (statWr && wrData[1])   timerFlag <= 1'b0;
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int TIMER_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq,
  output logic              timerIrq
);
  rtcStrobe_t strobe;
  logic [NUM_TIME-1:0][DATA_W-1:0]  timeVec;
  logic [NUM_ALARM-1:0][DATA_W-1:0] alarmVec;
  logic [NUM_ALARM-1:0]             alarmMask;
  logic stageAny, secAtMax, alarmMatch;
  logic alarmFlag, timerFlag, tmrRun, tmrRep;
  logic [TIMER_W-1:0] tmrIvl;

  rtc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeVec(timeVec), .alarmVec(alarmVec), .alarmMask(alarmMask),
    .stageAny(stageAny), .secAtMax(secAtMax), .alarmMatch(alarmMatch)
  );

  rtc_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMER_W(TIMER_W)) i_ctl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stageAny(stageAny), .secAtMax(secAtMax), .alarmMatch(alarmMatch),
    .strobe(strobe), .alarmFlag(alarmFlag), .timerFlag(timerFlag),
    .tmrIvl(tmrIvl), .tmrRun(tmrRun), .tmrRep(tmrRep)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(NUM_TIME))
      rdData = timeVec[rdAddr[2:0]];
    else if (rdAddr < ADDR_W'(A_MASK))
      rdData = alarmVec[3'(rdAddr - ADDR_W'(A_ALARM0))];
    else if (rdAddr == ADDR_W'(A_MASK))
      rdData = DATA_W'(alarmMask);
    else if (rdAddr == ADDR_W'(A_IVL))
      rdData = DATA_W'(tmrIvl);
    else if (rdAddr == ADDR_W'(A_TCTL))
      rdData = DATA_W'({tmrRep, tmrRun});
    else
      rdData = DATA_W'({timerFlag, alarmFlag});
  end

  assign alarmIrq = alarmFlag;
  assign timerIrq = timerFlag;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              alarmIrq,
  input logic              timerIrq,
  input logic [7*DATA_W-1:0] timeFlat
);
  logic [DATA_W-1:0] secVal;
  assign secVal = timeFlat[DATA_W-1:0];

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> $stable(timeFlat)); // R2

  AST_ALARM_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> ($past(secVal) == '0)); // R6

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !(wrEn && wrAddr == ADDR_W'(15) && wrData[0])) |=> alarmIrq); // R7

  AST_TIMER_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> $past(secTick)); // R8

  AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !(wrEn && wrAddr == ADDR_W'(15) && wrData[1])) |=> timerIrq); // R8
endmodule

bind cal_rtc cal_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .alarmIrq(alarmIrq), .timerIrq(timerIrq), .timeFlat(timeVec)
);

// File: tb/test_cal_rtc.sv
module test_cal_rtc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic alarmIrq, timerIrq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk; // 125 MHz

  cal_rtc i_cal_rtc (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .alarmIrq(alarmIrq), .timerIrq(timerIrq)
  );

  // order: sec, min, hour, dow, day, month, year, then expected after one increment
  localparam int NV = 10;
  localparam int VEC [NV][14] = '{
    '{15,30,12,2,10, 5,23,  16,30,12,2,10, 5,23},  // R2 plain second
    '{59,30,12,2,10, 5,23,   0,31,12,2,10, 5,23},  // R2 minute carry
    '{59,59,22,3,15, 7,50,   0, 0,23,3,15, 7,50},  // R2 hour carry
    '{59,59,23,3,30, 4,23,   0, 0, 0,4, 1, 5,23},  // R3 30-day month
    '{59,59,23,6,31, 1,23,   0, 0, 0,0, 1, 2,23},  // R3 dow wrap, 31-day month
    '{59,59,23,5,31,12,99,   0, 0, 0,6, 1, 1, 0},  // R3 year wrap
    '{59,59,23,6,28, 2,24,   0, 0, 0,0,29, 2,24},  // R4 leap Feb 28
    '{59,59,23,4,29, 2,24,   0, 0, 0,5, 1, 3,24},  // R4 leap Feb 29
    '{59,59,23,1,28, 2,23,   0, 0, 0,2, 1, 3,23},  // R4 common Feb
    '{59,59,23,0,28, 2, 0,   0, 0, 0,1,29, 2, 0}   // R4 year 00 leap
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rdAddr = 4'(a);
    #1;
    d = rdData;
  endtask

  task automatic readTime(output logic [55:0] t);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin
      rd(i, b);
      t[8*i +: 8] = b;
    end
  endtask

  task automatic setTime(input int s, input int mi, input int h, input int dw,
                         input int dy, input int mo, input int y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dy); wr(5, mo); wr(6, y);
    tick(); // staged values load
  endtask

  initial begin : watchdog
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [55:0] t, e, t2;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readTime(t);
    e = {8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0};
    check(t == e, "R1 reset time", t, e);
    rd(15, d);
    check(d == 8'd0 && !alarmIrq && !timerIrq, "R1 reset status", {d, alarmIrq, timerIrq}, 0);

    // R2 R3 R4 vector table
    for (int v = 0; v < NV; v++) begin
      setTime(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      tick();
      readTime(t);
      for (int i = 0; i < 7; i++) e[8*i +: 8] = 8'(VEC[v][7+i]);
      check(t == e, $sformatf("R2/R3/R4 vector %0d", v), t, e);
    end

    // R2 no change without tick
    readTime(t);
    repeat (5) @(negedge clk);
    readTime(t2);
    check(t2 == t, "R2 hold without tick", t2, t);

    // R5 staged write not visible before tick, loads without increment
    setTime(20, 10, 8, 1, 3, 3, 30);
    wr(1, 40);
    rd(1, d);
    check(d == 8'd10, "R5 staged minute not yet visible", d, 10);
    tick();
    rd(1, d);
    check(d == 8'd40, "R5 staged minute loaded", d, 40);
    rd(0, d);
    check(d == 8'd20, "R5 increment dropped on load", d, 20);

    // R5 write coinciding with tick
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd2; wrData = 8'd17; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    rd(2, d);
    check(d == 8'd17, "R5 coincident write loads", d, 17);
    rd(0, d);
    check(d == 8'd20, "R5 coincident tick dropped", d, 20);

    // R10 readback
    wr(8, 12); wr(7, 30); wr(12, 3);
    rd(8, d);  check(d == 8'd12, "R10 alarm hour readback", d, 12);
    rd(12, d); check(d == 8'd3, "R10 mask readback", d, 3);

    // R6 alarm on hour+minute
    setTime(58, 29, 12, 2, 10, 5, 23);
    tick(); tick();          // 59, then rollover to 12:30:00
    check(!alarmIrq, "R6 alarm not before eval cycle", alarmIrq, 0);
    @(negedge clk);
    check(alarmIrq, "R6 alarm hour+minute match", alarmIrq, 1);
    rd(15, d);
    check(d[0], "R6 status bit0", d, 1);
    // R7 sticky and clear
    tick(); tick();
    check(alarmIrq, "R7 alarm sticky", alarmIrq, 1);
    wr(15, 1);
    check(!alarmIrq, "R7 alarm cleared", alarmIrq, 0);

    // R6 year mismatch blocks alarm
    wr(11, 24); wr(12, 8'h13);
    setTime(59, 29, 12, 2, 10, 5, 23);
    tick(); @(negedge clk);
    check(!alarmIrq, "R6 year mismatch no alarm", alarmIrq, 0);

    // R6 day field alone
    wr(9, 10); wr(12, 8'h04);
    setTime(59, 14, 7, 2, 10, 5, 23);
    tick(); @(negedge clk);
    check(alarmIrq, "R6 day-only alarm", alarmIrq, 1);
    wr(15, 1);

    // R6 zero mask never fires
    wr(12, 0);
    setTime(59, 14, 7, 2, 10, 5, 23);
    tick(); @(negedge clk);
    check(!alarmIrq, "R6 zero mask no alarm", alarmIrq, 0);

    // R8 repeating timer, interval 3
    wr(13, 3); wr(14, 3);
    tick(); tick();
    check(!timerIrq, "R8 timer early", timerIrq, 0);
    tick();
    check(timerIrq, "R8 timer first interval", timerIrq, 1);
    wr(15, 2);
    check(!timerIrq, "R8 timer cleared", timerIrq, 0);
    tick(); tick(); tick();
    check(timerIrq, "R8 timer second interval", timerIrq, 1);

    // R9 one-shot timer, interval 2
    wr(14, 0); wr(15, 2); wr(13, 2); wr(14, 1);
    tick(); tick();
    check(timerIrq, "R9 one-shot fires", timerIrq, 1);
    rd(14, d);
    check(d == 8'd0, "R9 run bit cleared", d, 0);
    wr(15, 2);
    tick(); tick(); tick();
    check(!timerIrq, "R9 one-shot does not repeat", timerIrq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule